// File: doc/BRIEF.md
# Branch Target Buffer

This block sits beside the fetch stage and turns the current fetch address into the next fetch address within the same cycle. It is a direct-mapped table. Each slot holds a valid flag, the upper address bits of one branch, the target that branch last jumped to, and a small saturating confidence counter. A lookup reads the slot picked by the fetch address and compares the stored address bits for equality. If the slot matches and its counter leans toward taken, the stored target becomes the next fetch address. In every other case fetch moves on to the sequential word, fetch address plus four.

When a branch resolves, the update port writes its outcome into the table. A taken outcome creates a slot for the branch, or strengthens the slot it already has, and rewrites the target. A not-taken outcome only weakens a slot that already belongs to that branch; it never claims a slot. Every update is registered, so a lookup in the same cycle as an update still sees the old table contents.

Top module: `btb_core`

## Requirements
- R1: After reset every slot is empty. Every lookup then misses (`pred_hit`=0, `pred_taken`=0) and `next_pc` equals `fetch_pc`+4.
- R2: A lookup picks the slot with address bits [IDX_W+1:2]. It hits only when that slot is valid and its stored tag equals address bits [PC_W-1:IDX_W+2]. An address that shares the slot but has a different tag misses.
- R3: On a hit, `pred_taken` is 1 when the most significant counter bit is set (counter ≥ 2 for a 2-bit counter). `next_pc` is then the stored target. `pred_taken` is never 1 without `pred_hit`.
- R4: On a hit whose counter is below the taken threshold, `pred_hit`=1, `pred_taken`=0 and `next_pc`=`fetch_pc`+4.
- R5: A taken update whose address misses in its slot (slot empty, or holding another tag) replaces the slot. The new slot is valid, holds the new tag and target, and its counter is set to the weakly-taken value 2.
- R6: A taken update that hits its slot increments the counter, saturating at 3, and overwrites the stored target with the new one.
- R7: A not-taken update that hits its slot decrements the counter, saturating at 0. The slot stays valid and the stored target is unchanged.
- R8: A not-taken update that misses changes nothing. Any other branch held in that slot keeps its tag, target and counter.
- R9: An update takes effect at the next rising clock edge. A lookup in the same cycle as the update sees the table as it was before the update.
- R10: Address bits [1:0] of `fetch_pc` and `upd_pc` play no part in slot selection or tag comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | Current fetch address |
| next_pc | output | PC_W | Address to fetch next |
| pred_hit | output | 1 | Lookup matched a valid slot |
| pred_taken | output | 1 | Lookup matched and the counter predicts taken |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_target | input | PC_W | Resolved target address |

## Verification
The bench builds the block with PC_W=16 and ENTRIES=8, so the slot index is address bits [4:2]. Two addresses 0x20 apart then fall into the same slot, which makes aliasing and replacement easy to set up. The 2-bit counter can be driven to both saturation limits in a few updates, and each step is visible through the taken/not-taken output. The narrow address also keeps the targets short enough to compare directly.

// File: rtl/btb_pkg.sv
package btb_pkg;

    // Kind of change an update applies to the table.
    typedef enum logic [1:0] {
        UPD_NONE  = 2'd0,
        UPD_ALLOC = 2'd1,
        UPD_INC   = 2'd2,
        UPD_DEC   = 2'd3
    } upd_kind_e;

    // Saturating step of a confidence counter.
    function automatic logic [7:0] ctr_step(input logic [7:0] cur,
                                            input logic       up,
                                            input logic [7:0] max);
        logic [7:0] res;
        if (up) res = (cur == max) ? cur : cur + 8'd1;
        else    res = (cur == 8'd0) ? cur : cur - 8'd1;
        return res;
    endfunction

endpackage

// File: rtl/btb_pc_split.sv
module btb_pc_split #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6,
    localparam int TAG_W = PC_W - IDX_W - 2
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);
    logic unused_lo;

    always_comb begin
        idx       = pc[IDX_W+1:2];
        tag       = pc[PC_W-1:IDX_W+2];
        unused_lo = ^pc[1:0];
    end
endmodule

// File: rtl/btb_update_ctl.sv
module btb_update_ctl
    import btb_pkg::*;
#(
    parameter int CTR_W = 2
) (
    input  logic             upd_valid,
    input  logic             upd_taken,
    input  logic             slot_hit,
    input  logic [CTR_W-1:0] old_ctr,
    output upd_kind_e        kind,
    output logic [CTR_W-1:0] new_ctr
);
    localparam logic [CTR_W-1:0] CTR_MAX  = {CTR_W{1'b1}};
    localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'(1) << (CTR_W - 1);

    logic [7:0] step_res;

    always_comb begin
        kind     = UPD_NONE;
        step_res = ctr_step(8'(old_ctr), upd_taken, 8'(CTR_MAX));
        new_ctr  = old_ctr;
        if (upd_valid) begin
            if (upd_taken && !slot_hit) begin
                kind    = UPD_ALLOC;
                new_ctr = CTR_INIT;
            end else if (upd_taken) begin
                kind    = UPD_INC;
                new_ctr = step_res[CTR_W-1:0];
            end else if (slot_hit) begin
                kind    = UPD_DEC;
                new_ctr = step_res[CTR_W-1:0];
            end
        end
    end
endmodule

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 64,
    parameter int CTR_W   = 2,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = PC_W - IDX_W - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_vld,
    output logic [TAG_W-1:0] rd_tag,
    output logic [PC_W-1:0]  rd_tgt,
    output logic [CTR_W-1:0] rd_ctr,
    input  logic [IDX_W-1:0] up_idx,
    output logic             up_vld,
    output logic [TAG_W-1:0] up_tag_q,
    output logic [CTR_W-1:0] up_ctr,
    input  upd_kind_e        wr_kind,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PC_W-1:0]  wr_tgt,
    input  logic [CTR_W-1:0] wr_ctr
);
    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0][TAG_W-1:0] tag;
        logic [ENTRIES-1:0][PC_W-1:0]  tgt;
        logic [ENTRIES-1:0][CTR_W-1:0] ctr;
    } store_t;

    store_t             st_d, st_q;
    logic [ENTRIES-1:0] sel;

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_sel
            assign sel[g] = (up_idx == IDX_W'(g)) && (wr_kind != UPD_NONE);
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < ENTRIES; i++) begin
            if (sel[i]) begin
                st_d.ctr[i] = wr_ctr;
                if (wr_kind == UPD_ALLOC) begin
                    st_d.vld[i] = 1'b1;
                    st_d.tag[i] = wr_tag;
                end
                if (wr_kind != UPD_DEC) st_d.tgt[i] = wr_tgt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_vld   = st_q.vld[rd_idx];
        rd_tag   = st_q.tag[rd_idx];
        rd_tgt   = st_q.tgt[rd_idx];
        rd_ctr   = st_q.ctr[rd_idx];
        up_vld   = st_q.vld[up_idx];
        up_tag_q = st_q.tag[up_idx];
        up_ctr   = st_q.ctr[up_idx];
    end

    AST_TAKEN_WRITES_TGT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_kind == UPD_ALLOC || wr_kind == UPD_INC) |=>
            (st_q.tgt[$past(up_idx)] == $past(wr_tgt)) && st_q.vld[$past(up_idx)]); // R5

    AST_DEC_KEEPS_TGT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_kind == UPD_DEC) |=> (st_q.tgt == $past(st_q.tgt)) && (st_q.vld == $past(st_q.vld))); // R7

    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_kind == UPD_NONE) |=> (st_q == $past(st_q))); // R8

    AST_CTR_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_kind == UPD_INC && st_q.ctr[up_idx] == {CTR_W{1'b1}}) |=>
            (st_q.ctr[$past(up_idx)] == {CTR_W{1'b1}})); // R6

    AST_CTR_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_kind == UPD_DEC && st_q.ctr[up_idx] == '0) |=>
            (st_q.ctr[$past(up_idx)] == '0)); // R7
endmodule

// File: rtl/btb_core.sv
module btb_core
    import btb_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 64,
    parameter int CTR_W   = 2,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = PC_W - IDX_W - 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic [PC_W-1:0] next_pc,
    output logic            pred_hit,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target
);
    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic             rd_vld, up_vld;
    logic [TAG_W-1:0] rd_tag, up_tag_q;
    logic [PC_W-1:0]  rd_tgt;
    logic [CTR_W-1:0] rd_ctr, up_ctr, wr_ctr;
    logic             up_slot_hit;
    upd_kind_e        wr_kind;

    btb_pc_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_split_lk (
        .pc(fetch_pc), .idx(lk_idx), .tag(lk_tag)
    );

    btb_pc_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_split_up (
        .pc(upd_pc), .idx(up_idx), .tag(up_tag)
    );

    btb_store #(.PC_W(PC_W), .ENTRIES(ENTRIES), .CTR_W(CTR_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lk_idx), .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_tgt(rd_tgt), .rd_ctr(rd_ctr),
        .up_idx(up_idx), .up_vld(up_vld), .up_tag_q(up_tag_q), .up_ctr(up_ctr),
        .wr_kind(wr_kind), .wr_tag(up_tag), .wr_tgt(upd_target), .wr_ctr(wr_ctr)
    );

    assign up_slot_hit = up_vld && (up_tag_q == up_tag);

    btb_update_ctl #(.CTR_W(CTR_W)) u_ctl (
        .upd_valid(upd_valid), .upd_taken(upd_taken), .slot_hit(up_slot_hit),
        .old_ctr(up_ctr), .kind(wr_kind), .new_ctr(wr_ctr)
    );

    always_comb begin
        pred_hit   = rd_vld && (rd_tag == lk_tag);
        pred_taken = pred_hit && rd_ctr[CTR_W-1];
        next_pc    = pred_taken ? rd_tgt : fetch_pc + PC_W'(4);
    end

    AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> pred_hit); // R3

    AST_NT_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && !up_slot_hit) |-> (wr_kind == UPD_NONE)); // R8
endmodule

// File: tb/btb_core_tb_top.sv
module btb_core_tb_top;
    localparam int PC_W = 16;
    localparam int ENT  = 8;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [PC_W-1:0] fetch_pc;
    logic [PC_W-1:0] next_pc;
    logic            pred_hit, pred_taken;
    logic            upd_valid;
    logic [PC_W-1:0] upd_pc;
    logic            upd_taken;
    logic [PC_W-1:0] upd_target;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    btb_core #(.PC_W(PC_W), .ENTRIES(ENT), .CTR_W(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .next_pc(next_pc),
        .pred_hit(pred_hit), .pred_taken(pred_taken), .upd_valid(upd_valid),
        .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target)
    );

    task automatic look(input logic [PC_W-1:0] pc, input logic eh, input logic et,
                        input logic [PC_W-1:0] en, input string req);
        fetch_pc = pc;
        #1;
        total++;
        if (pred_hit !== eh || pred_taken !== et || next_pc !== en) begin
            bad++;
            $display("FAIL %s pc=%h: hit=%b taken=%b next=%h expected hit=%b taken=%b next=%h",
                     req, pc, pred_hit, pred_taken, next_pc, eh, et, en);
        end
    endtask

    task automatic upd(input logic [PC_W-1:0] pc, input logic tk, input logic [PC_W-1:0] tgt);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tgt;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic t_reset();
        look(16'h0100, 0, 0, 16'h0104, "R1");
        look(16'h0000, 0, 0, 16'h0004, "R1");
        look(16'hFFFC, 0, 0, 16'h0000, "R1");
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = 16'h0100; upd_taken = 1'b1; upd_target = 16'h0200;
        look(16'h0100, 0, 0, 16'h0104, "R9");
        @(negedge clk);
        upd_valid = 1'b0;
        look(16'h0100, 1, 1, 16'h0200, "R5");
        look(16'h0103, 1, 1, 16'h0200, "R10");
    endtask

    task automatic t_counter();
        upd(16'h0100, 1, 16'h0200);
        upd(16'h0100, 1, 16'h0200);
        upd(16'h0100, 1, 16'h0240);
        look(16'h0100, 1, 1, 16'h0240, "R6");
        upd(16'h0100, 0, 16'h0BAD);
        look(16'h0100, 1, 1, 16'h0240, "R7");
        upd(16'h0100, 0, 16'h0BAD);
        look(16'h0100, 1, 0, 16'h0104, "R4");
        upd(16'h0100, 0, 16'h0BAD);
        upd(16'h0100, 0, 16'h0BAD);
        upd(16'h0100, 1, 16'h0240);
        look(16'h0100, 1, 0, 16'h0104, "R7");
        upd(16'h0100, 1, 16'h0280);
        look(16'h0100, 1, 1, 16'h0280, "R6");
    endtask

    task automatic t_alias();
        look(16'h0120, 0, 0, 16'h0124, "R2");
        upd(16'h0121, 0, 16'h0BAD);
        look(16'h0100, 1, 1, 16'h0280, "R8");
        look(16'h0120, 0, 0, 16'h0124, "R8");
        upd(16'h0120, 1, 16'h0300);
        look(16'h0120, 1, 1, 16'h0300, "R5");
        look(16'h0100, 0, 0, 16'h0104, "R2");
        upd(16'h0120, 0, 16'h0BAD);
        look(16'h0120, 1, 0, 16'h0124, "R5");
        upd(16'h0104, 1, 16'h0400);
        look(16'h0104, 1, 1, 16'h0400, "R2");
        look(16'h0120, 1, 0, 16'h0124, "R2");
    endtask

    initial begin
        rst_n = 1'b0; fetch_pc = '0; upd_valid = 1'b0; upd_pc = '0;
        upd_taken = 1'b0; upd_target = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_same_cycle();
        t_counter();
        t_alias();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++; bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule